// File: doc/BRIEF.md
# I2C SCL Clock Synchronization Generator

This block produces the master clock waveform for a two-wire bus whose clock line is wired-AND. It never drives the line high. It asserts a single open-drain enable that pulls the clock low, and it releases that enable to let the line float high. The block has a programmable low period and a programmable high period, both counted in system-clock cycles. It follows the real line level, seen through a synchronizer, and does not trust its own drive. Other masters and clock-stretching slaves can therefore lengthen a low phase or cut a high phase short.

A low phase ends when the block's low count expires and it lets go of the line. The block then stays in a wait state for as long as any other device still holds the line low. It starts counting its high period only after it actually sees the line high. When the line falls for any reason, the block starts a new low phase. Several such generators on one bus therefore agree on one clock. The low time of that clock is the longest of their low settings, and the high time is the shortest of their high settings, each extended by the synchronizer delay. Single-cycle strobes report each rising and falling edge of the synchronized line to a bit engine. There is no data stream at this block, so every pin is a plain control or status level.

Top module: `scl_sync_gen`

## Requirements
- R1: Each low phase asserts scl_pull_low for exactly max(low_len,1) consecutive cycles.
- R2: After reset, and from the cycle after en goes low, scl_pull_low, scl_rise and scl_fall are all 0.
- R3: After its low count expires, the block keeps the line released while another device holds it low, with no limit on the wait. It starts a new pull exactly SYNC_STAGES+1+max(high_len,1) cycles after the line is released.
- R4: With no other device on the bus, the released interval between two pulls is max(high_len,1)+SYNC_STAGES+1 cycles.
- R5: If another device pulls the line low during this block's high count, the block's own pull begins exactly SYNC_STAGES+1 cycles later. The block then runs a full low phase.
- R6: scl_fall and scl_rise each pulse for one cycle, once per falling or rising edge of scl_in, SYNC_STAGES cycles after the edge.
- R7: When en rises on an idle-high bus, the block does not pull in the next cycle. Its first pull begins exactly 2+max(high_len,1) cycles after en rises.
- R8: Two generators share one line, with effective lows La, Lb and highs Ha, Hb, where Ha is not equal to Hb and each low is at least SYNC_STAGES+2. The line's high time is min(Ha,Hb)+SYNC_STAGES+1. Its low time is max(Llead, d+Lfollow), where the lead is the one with the smaller high and d=min(|Ha-Hb|, SYNC_STAGES+1). When Ha equals Hb, the low time is max(La,Lb).
- R9: A low_len or high_len of 0 behaves as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low releases the line and clears the counters |
| low_len | input | CNT_W | Low period in clock cycles |
| high_len | input | CNT_W | High period in clock cycles |
| scl_in | input | 1 | Raw level of the shared clock line |
| scl_pull_low | output | 1 | Open-drain enable; 1 pulls the line low |
| scl_rise | output | 1 | One-cycle strobe for a synchronized rising edge |
| scl_fall | output | 1 | One-cycle strobe for a synchronized falling edge |

## Verification
The properties assume that low_len and high_len change only while en is low. They also assume that scl_in is the wired-AND of this block's own pull and every other driver, so the line is never seen high while this block pulls it. Each low pulse from any driver is assumed to last at least one clock. The stimulus builds the line as the AND of two instances and one bench-driven pull, and it reprograms the periods only while both instances are disabled. The random two-master trials keep every low setting above the synchronizer delay, so that the lead master's pulse always overlaps the follower's.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  // Clock phases of the generator.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,  // disabled, line released
    PH_ARM  = 3'd1,  // enabled, waiting for an idle-high line
    PH_LOW  = 3'd2,  // pulling low, counting low period
    PH_WAIT = 3'd3,  // released, line still held low elsewhere
    PH_HIGH = 3'd4   // line seen high, counting high period
  } scl_phase_e;
endpackage

// File: rtl/scl_bus_sync.sv
module scl_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= scl_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/scl_period_cnt.sv
module scl_period_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] period,
  output logic         done
);
  logic [W-1:0] cnt;

  // A period of 0 finishes after one cycle, like a period of 1.
  assign done = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (!done) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic             cnt_done,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output logic             cnt_clear,
  output logic [CNT_W-1:0] period,
  output logic             pull
);
  scl_phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = PH_IDLE;
    end else begin
      case (state_q)
        PH_IDLE: state_d = PH_ARM;
        PH_ARM:  if (lvl) state_d = PH_HIGH;
        // An edge from any device, or our own expiry, opens a low phase.
        PH_HIGH: if (fall || cnt_done) state_d = PH_LOW;
        PH_LOW:  if (cnt_done) state_d = PH_WAIT;
        // Only a fresh rising edge ends the wait; a stale high is ignored.
        PH_WAIT: if (rise) state_d = PH_HIGH;
        default: state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign cnt_clear = (state_d != state_q) ||
                     !((state_q == PH_LOW) || (state_q == PH_HIGH));
  assign period    = (state_q == PH_LOW) ? low_len : high_len;
  assign pull      = (state_q == PH_LOW);
endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             scl_rise,
  output logic             scl_fall
);
  logic             lvl, rise_s, fall_s;
  logic             cnt_clear, cnt_done;
  logic [CNT_W-1:0] period;

  scl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_raw (scl_in),
    .lvl     (lvl),
    .rise    (rise_s),
    .fall    (fall_s)
  );

  scl_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .lvl       (lvl),
    .rise      (rise_s),
    .fall      (fall_s),
    .cnt_done  (cnt_done),
    .low_len   (low_len),
    .high_len  (high_len),
    .cnt_clear (cnt_clear),
    .period    (period),
    .pull      (scl_pull_low)
  );

  scl_period_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .period (period),
    .done   (cnt_done)
  );

  assign scl_rise = en & rise_s;
  assign scl_fall = en & fall_s;
endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] low_len,
  input logic [CNT_W-1:0] high_len,
  input logic             scl_in,
  input logic             scl_pull_low
);
  localparam int RW = CNT_W + 2;
  localparam logic [RW-1:0] LAT = RW'(SYNC_STAGES + 1);

  logic [RW-1:0] eff_lo, eff_hi, lo_run, hi_run;
  logic          free_high;

  assign eff_lo    = (low_len == '0)  ? RW'(1) : RW'(low_len);
  assign eff_hi    = (high_len == '0) ? RW'(1) : RW'(high_len);
  assign free_high = en && !scl_pull_low && scl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= scl_pull_low ? ((&lo_run) ? lo_run : lo_run + RW'(1)) : '0;
      hi_run <= free_high    ? ((&hi_run) ? hi_run : hi_run + RW'(1)) : '0;
    end
  end

  // R1: a pull never lasts longer than the low setting
  p_pull_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> (lo_run < eff_lo));

  // R2: a disabled block lets the line go
  p_release_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull_low);

  // R4: a released, high line is pulled again within high setting plus latency
  p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_high |-> (hi_run < eff_hi + LAT));

  // R7: enabling never pulls in the very next cycle
  p_arm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !scl_pull_low);
endmodule

bind scl_sync_gen scl_sync_gen_chk #(
  .CNT_W       (CNT_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .low_len      (low_len),
  .high_len     (high_len),
  .scl_in       (scl_in),
  .scl_pull_low (scl_pull_low)
);

// File: tb/sim_scl_sync_gen.sv
module sim_scl_sync_gen;
  localparam int W   = 12;
  localparam int S   = 2;
  localparam int LAT = S + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         en0 = 1'b0, en1 = 1'b0, ext_low = 1'b0;
  logic [W-1:0] lo0 = '0, hi0 = '0, lo1 = '0, hi1 = '0;
  logic         p0, p1, r0, f0, r1, f1;
  logic         bus;

  assign bus = ~(p0 | p1 | ext_low);

  scl_sync_gen #(.CNT_W(W), .SYNC_STAGES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en0), .low_len(lo0), .high_len(hi0),
    .scl_in(bus), .scl_pull_low(p0), .scl_rise(r0), .scl_fall(f0));

  scl_sync_gen #(.CNT_W(W), .SYNC_STAGES(S)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en1), .low_len(lo1), .high_len(hi1),
    .scl_in(bus), .scl_pull_low(p1), .scl_rise(r1), .scl_fall(f1));

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_high2(input int ha, input int hb);
    return ((eff(ha) < eff(hb)) ? eff(ha) : eff(hb)) + LAT;
  endfunction

  function automatic int exp_low2(input int la, input int lb, input int ha, input int hb);
    int a, b, d, lead, fol;
    a = eff(ha); b = eff(hb);
    d = (a > b) ? a - b : b - a;
    if (d > LAT) d = LAT;
    lead = (a <= b) ? eff(la) : eff(lb);
    fol  = (a <= b) ? eff(lb) : eff(la);
    return (lead > d + fol) ? lead : d + fol;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int lo, output int hi);
    do @(negedge clk); while (bus !== 1'b1);
    do @(negedge clk); while (bus !== 1'b0);
    lo = 0;
    while (bus === 1'b0) begin lo++; @(negedge clk); end
    hi = 0;
    while (bus === 1'b1) begin hi++; @(negedge clk); end
  endtask

  // edge and strobe counters for R6
  bit cnt_bus = 0, cnt_str = 0;
  logic bus_q = 1'b1;
  int nbf = 0, nbr = 0, nsf = 0, nsr = 0;
  always @(negedge clk) begin
    if (cnt_bus) begin
      if (bus_q && !bus) nbf++;
      if (!bus_q && bus) nbr++;
    end
    if (cnt_str) begin
      if (f0) nsf++;
      if (r0) nsr++;
    end
    bus_q = bus;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lo, hi, n;
    void'($urandom(32'h5EED));

    // R2: reset state
    step(2);
    chk(p0 === 1'b0 && r0 === 1'b0 && f0 === 1'b0, "R2 reset outputs", p0, 0);
    rst_n = 1'b1;
    step(4);
    chk(p0 === 1'b0, "R2 idle after reset", p0, 0);

    // R7: enable from idle-high bus, first pull after 2+H
    hi0 = 12'd7; lo0 = 12'd5;
    en0 = 1'b1;
    step(1);
    chk(p0 === 1'b0, "R7 no pull after enable", p0, 0);
    step(2 + 7 - 1 - 1);
    chk(p0 === 1'b0, "R7 still released", p0, 0);
    step(1);
    chk(p0 === 1'b1, "R7 first pull time", p0, 1);

    // R1/R4: single master timing
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 5, "R1 low length", lo, 5);
    chk(hi == 7 + LAT, "R4 high length", hi, 7 + LAT);

    // R9: zero settings behave as one
    en0 = 1'b0; step(3);
    lo0 = '0; hi0 = '0; en0 = 1'b1;
    measure(lo, hi);
    measure(lo, hi);
    chk(lo == 1, "R9 zero low", lo, 1);
    chk(hi == 1 + LAT, "R9 zero high", hi, 1 + LAT);

    // R5: external pull during our high count
    en0 = 1'b0; step(3);
    lo0 = 12'd6; hi0 = 12'd30; en0 = 1'b1;
    do @(negedge clk); while (p0 !== 1'b1);
    do @(negedge clk); while (p0 !== 1'b0);
    step(LAT + 4);
    ext_low = 1'b1;
    step(LAT - 1);
    chk(p0 === 1'b0, "R5 not yet pulling", p0, 0);
    step(1);
    chk(p0 === 1'b1, "R5 pull after latency", p0, 1);
    ext_low = 1'b0;
    n = 1;
    @(negedge clk);
    while (p0 === 1'b1) begin n++; @(negedge clk); end
    chk(n == 6, "R5 R1 full low after early end", n, 6);

    // R3: another device holds the line long after our low expires
    step(LAT + 4);
    ext_low = 1'b1;
    step(20);
    chk(p0 === 1'b0, "R3 released while held", p0, 0);
    step(29);
    chk(p0 === 1'b0, "R3 still waiting", p0, 0);
    step(1);
    ext_low = 1'b0;
    step(LAT + 30 - 1);
    chk(p0 === 1'b0, "R3 high count not done", p0, 0);
    step(1);
    chk(p0 === 1'b1, "R3 pull after high count", p0, 1);

    // R6: strobes mirror line edges
    en0 = 1'b0; step(3);
    lo0 = 12'd4; hi0 = 12'd5; en0 = 1'b1;
    step(20);
    @(posedge clk); cnt_bus = 1;
    repeat (S) @(posedge clk); cnt_str = 1;
    repeat (100 - S) @(posedge clk); cnt_bus = 0;
    repeat (S) @(posedge clk); cnt_str = 0;
    step(1);
    chk(nbf > 0, "R6 edges seen", nbf, 1);
    chk(nsf == nbf, "R6 fall strobes", nsf, nbf);
    chk(nsr == nbr, "R6 rise strobes", nsr, nbr);

    // R2: disable during a low phase
    en0 = 1'b0; step(3);
    lo0 = 12'd20; hi0 = 12'd5; en0 = 1'b1;
    do @(negedge clk); while (p0 !== 1'b1);
    step(2);
    en0 = 1'b0;
    step(1);
    chk(p0 === 1'b0, "R2 release on disable", p0, 0);
    n = 0;
    repeat (10) begin
      @(negedge clk);
      if (p0 !== 1'b0 || r0 !== 1'b0 || f0 !== 1'b0) n++;
    end
    chk(n == 0, "R2 quiet while disabled", n, 0);

    // R8: two masters, random settings with a few directed cases
    for (int it = 0; it < 22; it++) begin
      int la, lb, ha, hb;
      en0 = 1'b0; en1 = 1'b0; step(4);
      if (it == 0)      begin la = 10; lb = 10; ha = 6;  hb = 6;  end
      else if (it == 1) begin la = 4;  lb = 20; ha = 3;  hb = 15; end
      else if (it == 2) begin la = 20; lb = 4;  ha = 9;  hb = 8;  end
      else begin
        la = $urandom_range(24, S + 2); lb = $urandom_range(24, S + 2);
        ha = $urandom_range(24, 1);     hb = $urandom_range(24, 1);
      end
      lo0 = W'(la); hi0 = W'(ha); lo1 = W'(lb); hi1 = W'(hb);
      en0 = 1'b1; en1 = 1'b1;
      measure(lo, hi);
      measure(lo, hi);
      measure(lo, hi);
      chk(lo == exp_low2(la, lb, ha, hb), "R8 shared low", lo, exp_low2(la, lb, ha, hb));
      chk(hi == exp_high2(ha, hb), "R8 shared high", hi, exp_high2(ha, hb));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule